// File: doc/BRIEF.md
# Ready-Polled Serial ADC Readout Controller

This block is the host side of a SPI link to a multi-channel delta-sigma converter whose serial data output also acts as a conversion-ready flag. Once out of reset the controller keeps chip select asserted and watches that shared line. A low level means a new result is waiting. The controller then shifts out a one-byte read command for the converter's data register. It clocks in the 24-bit conversion and, when status appending is enabled, one more status byte.

The low nibble of the status byte names the converter channel that produced the word. The controller writes the word into that channel's result register and pulses that channel's valid strobe. With status appending off, every word goes to channel 0.

After each read, the controller ignores the ready line for a programmable guard time. It raises a sticky error flag if the line stays high longer than a programmable limit while it waits. The serial clock runs in mode 3 (idle high, launch on falling edge, capture on rising edge). Its rate is a programmable divide of the system clock.

Top module: `adc_drdy_reader`

## Requirements
- R1: While reset is asserted, chip select is high, the serial clock is high, no valid strobe is set and the error flag is low. From the first cycles after reset release, chip select stays low.
- R2: A read starts only when the shared data-out/ready line is seen low while waiting. Each read begins with the command byte 0x42 (read flag in bit 6, register address 2 in bits 5..0), sent MSB first. MOSI changes on falling serial-clock edges, and the serial clock idles high between reads.
- R3: Each serial-clock half period lasts `sclk_div + 1` system-clock cycles.
- R4: With `status_en` low, a read is 32 serial-clock cycles long. The 24 bits after the command form the result, MSB first, and are written to channel 0's register.
- R5: With `status_en` high, a read is 40 serial-clock cycles long. The last 8 bits are a status byte, and its bits 3..0 select the destination channel.
- R6: A status channel index of `NCH` or above discards the word: no valid strobe is raised and no result register changes.
- R7: Each stored word raises exactly one valid bit, that of its channel, for exactly one cycle. Registers of other channels keep their contents.
- R8: For at least `guard_cycles` cycles after a read ends, a low level on the ready line does not start a read. A low pulse that ends within the guard window produces no serial-clock activity.
- R9: `timeout_err` rises when the ready line stays high longer than `timeout_cycles` cycles while waiting. It clears when the next read starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| status_en | input | 1 | Converter appends a status byte to each word |
| sclk_div | input | CNTW | Serial-clock half period minus one, in system cycles |
| guard_cycles | input | CNTW | Ready-ignore window after each read |
| timeout_cycles | input | CNTW | Longest permitted wait for ready |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, mode 3 |
| spi_mosi | output | 1 | Command data to converter |
| spi_miso | input | 1 | Shared data-out / ready line |
| res_data | output | NCH*DW | Per-channel result registers, channel 0 in the low bits |
| res_valid | output | NCH | Per-channel one-cycle update strobes |
| timeout_err | output | 1 | Ready wait exceeded the limit |

## Verification
On every cycle, the embedded properties check the following: the serial clock is idle-high outside a read and steady between divider ticks, the valid vector is at most one-hot and never two cycles in a row, no read starts inside the guard window, the frame length matches the status mode, and the error flag rises only while waiting. The bench alone can show that the command byte is correct and that words and channel tags travel intact from the line to the right register. It also shows that unaddressed and out-of-range channels keep their values, that the half period follows the divider, and that a short low pulse inside the guard window is ignored.

// File: rtl/adc_drdy_pkg.sv
package adc_drdy_pkg;
    localparam int CHW = 4;
    localparam int CMDW = 8;
    localparam int STW = 8;
    localparam logic [CMDW-1:0] CMD_READ_DATA = 8'h42;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_XFER  = 2'd1,
        ST_GUARD = 2'd2
    } rd_state_e;
endpackage

// File: rtl/adc_drdy_sclk_gen.sv
module adc_drdy_sclk_gen #(
    parameter int CNTW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [CNTW-1:0] div,
    output logic            sclk,
    output logic            fall_tk,
    output logic            rise_tk
);
    typedef struct packed {
        logic [CNTW-1:0] cnt;
        logic            sclk;
    } gen_regs_t;

    gen_regs_t q, d;

    always_comb begin
        d = q;
        if (!run) begin
            d.cnt  = div;
            d.sclk = 1'b1;
        end else if (q.cnt == '0) begin
            d.cnt  = div;
            d.sclk = ~q.sclk;
        end else begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt  <= '0;
            q.sclk <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk    = q.sclk;
    assign fall_tk = run && (q.cnt == '0) && q.sclk;
    assign rise_tk = run && (q.cnt == '0) && !q.sclk;

    // R3: the clock edge only moves when the divider expires
    a_r3_sclk_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (run && q.cnt != '0) |=> $stable(sclk));
endmodule

// File: rtl/adc_drdy_shift_eng.sv
module adc_drdy_shift_eng
    import adc_drdy_pkg::*;
#(
    parameter int DW = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           status_en,
    input  logic           fall_tk,
    input  logic           rise_tk,
    input  logic           miso,
    output logic           busy,
    output logic           mosi,
    output logic           done,
    output logic [DW-1:0]  word,
    output logic [CHW-1:0] chan
);
    localparam int RXW      = DW + STW;
    localparam int FR_PLAIN = CMDW + DW;
    localparam int FR_STAT  = CMDW + DW + STW;
    localparam int IW       = $clog2(FR_STAT + 1);
    localparam logic [IW-1:0] LAST_PLAIN = IW'(FR_PLAIN - 1);
    localparam logic [IW-1:0] LAST_STAT  = IW'(FR_STAT - 1);
    localparam logic [IW-1:0] CMD_BITS   = IW'(CMDW);

    typedef struct packed {
        logic            busy;
        logic            st_en;
        logic [IW-1:0]   idx;
        logic [CMDW-1:0] tx;
        logic [RXW-1:0]  rx;
        logic            mosi;
        logic            done;
    } eng_regs_t;

    eng_regs_t q, d;
    logic [IW-1:0] last_idx;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        last_idx = q.st_en ? LAST_STAT : LAST_PLAIN;
        if (!q.busy) begin
            if (start) begin
                d.busy  = 1'b1;
                d.st_en = status_en;
                d.idx   = '0;
                d.tx    = CMD_READ_DATA;
                d.rx    = '0;
            end
        end else begin
            if (fall_tk) begin
                d.mosi = q.tx[CMDW-1];
                d.tx   = {q.tx[CMDW-2:0], 1'b0};
            end
            if (rise_tk) begin
                if (q.idx >= CMD_BITS) begin
                    d.rx = {q.rx[RXW-2:0], miso};
                end
                d.idx = q.idx + 1'b1;
                if (q.idx == last_idx) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.busy  <= 1'b0;
            q.st_en <= 1'b0;
            q.idx   <= '0;
            q.tx    <= '0;
            q.rx    <= '0;
            q.mosi  <= 1'b1;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy = q.busy;
    assign mosi = q.mosi;
    assign done = q.done;
    assign word = q.st_en ? q.rx[RXW-1:STW] : q.rx[DW-1:0];
    assign chan = q.st_en ? q.rx[CHW-1:0] : '0;

    // R4 / R5: frame length follows the status mode latched at start
    a_r5_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (q.idx == (q.st_en ? IW'(FR_STAT) : IW'(FR_PLAIN))));
    // R2: a new frame is only accepted while idle
    a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy || done));
endmodule

// File: rtl/adc_drdy_result_bank.sv
module adc_drdy_result_bank
    import adc_drdy_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHW-1:0]    wr_ch,
    input  logic [DW-1:0]     wr_data,
    output logic [NCH*DW-1:0] data,
    output logic [NCH-1:0]    valid
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        typedef struct packed {
            logic [DW-1:0] val;
            logic          stb;
        } slot_regs_t;

        slot_regs_t q, d;
        logic hit;

        assign hit = wr_en && (wr_ch == CHW'(i));

        always_comb begin
            d     = q;
            d.stb = hit;
            if (hit) begin
                d.val = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q.val <= '0;
                q.stb <= 1'b0;
            end else begin
                q <= d;
            end
        end

        assign data[i*DW +: DW] = q.val;
        assign valid[i]         = q.stb;

        // R7: a register only changes together with its strobe
        a_r7_hold_unless_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            !valid[i] |-> $stable(data[i*DW +: DW]));
    end

    // R7: one channel at a time, one cycle long
    a_r7_valid_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(valid));
    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        (|valid) |=> !(|valid));
endmodule

// File: rtl/adc_drdy_reader.sv
module adc_drdy_reader
    import adc_drdy_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int DW   = 24,
    parameter int CNTW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              status_en,
    input  logic [CNTW-1:0]   sclk_div,
    input  logic [CNTW-1:0]   guard_cycles,
    input  logic [CNTW-1:0]   timeout_cycles,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NCH*DW-1:0] res_data,
    output logic [NCH-1:0]    res_valid,
    output logic              timeout_err
);
    typedef struct packed {
        rd_state_e       st;
        logic [CNTW-1:0] gcnt;
        logic [CNTW-1:0] tcnt;
        logic            err;
        logic            cs_n;
        logic [1:0]      sync;
    } top_regs_t;

    top_regs_t q, d;

    logic           start;
    logic           wr_en;
    logic           eng_busy;
    logic           eng_done;
    logic           fall_tk;
    logic           rise_tk;
    logic [DW-1:0]  eng_word;
    logic [CHW-1:0] eng_chan;
    logic           rdy_low;

    assign rdy_low = !q.sync[1];

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], spi_miso};
        d.cs_n = 1'b0;
        start  = 1'b0;
        wr_en  = 1'b0;
        unique case (q.st)
            ST_WAIT: begin
                if (!q.cs_n && rdy_low) begin
                    start  = 1'b1;
                    d.st   = ST_XFER;
                    d.err  = 1'b0;
                    d.tcnt = '0;
                end else if (q.tcnt != timeout_cycles) begin
                    d.tcnt = q.tcnt + 1'b1;
                end else begin
                    d.err = 1'b1;
                end
            end
            ST_XFER: begin
                if (eng_done) begin
                    wr_en  = 1'b1;
                    d.st   = ST_GUARD;
                    d.gcnt = '0;
                end
            end
            ST_GUARD: begin
                if (q.gcnt >= guard_cycles) begin
                    d.st = ST_WAIT;
                end else begin
                    d.gcnt = q.gcnt + 1'b1;
                end
            end
            default: d.st = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_WAIT;
            q.gcnt <= '0;
            q.tcnt <= '0;
            q.err  <= 1'b0;
            q.cs_n <= 1'b1;
            q.sync <= 2'b11;
        end else begin
            q <= d;
        end
    end

    adc_drdy_sclk_gen #(.CNTW(CNTW)) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (eng_busy),
        .div     (sclk_div),
        .sclk    (spi_sclk),
        .fall_tk (fall_tk),
        .rise_tk (rise_tk)
    );

    adc_drdy_shift_eng #(.DW(DW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .status_en (status_en),
        .fall_tk   (fall_tk),
        .rise_tk   (rise_tk),
        .miso      (spi_miso),
        .busy      (eng_busy),
        .mosi      (spi_mosi),
        .done      (eng_done),
        .word      (eng_word),
        .chan      (eng_chan)
    );

    adc_drdy_result_bank #(.NCH(NCH), .DW(DW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ch   (eng_chan),
        .wr_data (eng_word),
        .data    (res_data),
        .valid   (res_valid)
    );

    assign spi_cs_n    = q.cs_n;
    assign timeout_err = q.err;

    // R2: serial clock rests high whenever no frame is running
    a_r2_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> spi_sclk);
    // R8: no frame is launched from the guard window
    a_r8_guard_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_GUARD) |=> !eng_busy);
    // R9: error flag can only rise while waiting for ready
    a_r9_err_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> $past(q.st == ST_WAIT));
    // R1: chip select stays asserted once out of reset
    a_r1_cs_held: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |=> !spi_cs_n);
endmodule

// File: tb/adc_drdy_reader_tb_top.sv
module adc_drdy_reader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 4;
    localparam int DW   = 24;
    localparam int CNTW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              status_en = 1'b1;
    logic [CNTW-1:0]   sclk_div = 16'd1;
    logic [CNTW-1:0]   guard_cycles = 16'd40;
    logic [CNTW-1:0]   timeout_cycles = 16'd200;
    logic              spi_cs_n;
    logic              spi_sclk;
    logic              spi_mosi;
    logic              spi_miso = 1'b1;
    logic [NCH*DW-1:0] res_data;
    logic [NCH-1:0]    res_valid;
    logic              timeout_err;

    int checks = 0;
    int fails  = 0;
    int rises  = 0;
    logic [DW-1:0] mdl [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge spi_sclk) rises++;

    adc_drdy_reader #(.NCH(NCH), .DW(DW), .CNTW(CNTW)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .status_en      (status_en),
        .sclk_div       (sclk_div),
        .guard_cycles   (guard_cycles),
        .timeout_cycles (timeout_cycles),
        .spi_cs_n       (spi_cs_n),
        .spi_sclk       (spi_sclk),
        .spi_mosi       (spi_mosi),
        .spi_miso       (spi_miso),
        .res_data       (res_data),
        .res_valid      (res_valid),
        .timeout_err    (timeout_err)
    );

    function automatic int exp_dest(input logic [3:0] ch, input bit st);
        if (!st) return 0;
        if (int'(ch) < NCH) return int'(ch);
        return -1;
    endfunction

    function automatic logic [NCH-1:0] exp_mask(input int dest);
        if (dest < 0) return '0;
        return NCH'(1) << dest;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [3:0] ch, input logic [DW-1:0] val, input bit st);
        logic [7:0]    cmd;
        logic [7:0]    stb;
        logic [31:0]   frame;
        logic [NCH-1:0] vmask;
        int nd;
        int dest;
        int seen;
        int r0;
        time tf;
        stb = {4'($urandom), ch};
        frame = st ? {val, stb} : {8'h00, val};
        nd = st ? 32 : 24;
        cmd = '0;
        vmask = '0;
        seen = 0;
        status_en = st;
        r0 = rises;
        @(negedge clk);
        spi_miso = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge spi_sclk);
            tf = $time;
            @(posedge spi_sclk);
            cmd = {cmd[6:0], spi_mosi};
            if (i == 0) begin
                // R3: half period equals sclk_div + 1 system cycles
                chk(($time - tf) == time'((int'(sclk_div) + 1) * CLK_PERIOD), "R3 half period",
                    longint'($time - tf), longint'((int'(sclk_div) + 1) * CLK_PERIOD));
            end
        end
        for (int i = 0; i < nd; i++) begin
            @(negedge spi_sclk);
            spi_miso = frame[nd-1-i];
            @(posedge spi_sclk);
        end
        spi_miso = 1'b1;
        chk(cmd == 8'h42, "R2 command byte", longint'(cmd), 64'h42);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (res_valid != '0) begin
                seen++;
                vmask = res_valid;
            end
        end
        dest = exp_dest(ch, st);
        if (dest >= 0) mdl[dest] = val;
        // R6 / R7: strobe of the addressed channel only, or none when discarded
        chk(vmask == exp_mask(dest), dest < 0 ? "R6 discard mask" : "R7 valid mask",
            longint'(vmask), longint'(exp_mask(dest)));
        chk(seen == (dest >= 0 ? 1 : 0), "R7 strobe length", longint'(seen),
            longint'(dest >= 0 ? 1 : 0));
        // R4 / R5: frame length in serial clocks
        chk((rises - r0) == 8 + nd, st ? "R5 frame length" : "R4 frame length",
            longint'(rises - r0), longint'(8 + nd));
        for (int c = 0; c < NCH; c++) begin
            chk(res_data[c*DW +: DW] == mdl[c], "R7 register contents",
                longint'(res_data[c*DW +: DW]), longint'(mdl[c]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int r0;
        void'($urandom(32'd2024));
        for (int c = 0; c < NCH; c++) mdl[c] = '0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(spi_cs_n == 1'b1, "R1 cs in reset", longint'(spi_cs_n), 1);
        chk(spi_sclk == 1'b1, "R1 sclk in reset", longint'(spi_sclk), 1);
        chk(res_valid == '0, "R1 valid in reset", longint'(res_valid), 0);
        chk(timeout_err == 1'b0, "R1 err in reset", longint'(timeout_err), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b0, "R1 cs after reset", longint'(spi_cs_n), 0);

        // directed corners
        do_read(4'd2, 24'hABCDEF, 1'b1);
        repeat (60) @(negedge clk);
        do_read(4'd0, 24'h000001, 1'b0);
        repeat (60) @(negedge clk);
        do_read(4'hF, 24'h123456, 1'b1);   // R6 out of range
        repeat (60) @(negedge clk);
        do_read(4'd3, 24'hFFFFFF, 1'b1);
        repeat (60) @(negedge clk);
        do_read(4'd5, 24'h800000, 1'b0);   // R4 tag ignored in plain mode
        repeat (60) @(negedge clk);
        do_read(4'd4, 24'h55AA55, 1'b1);   // R6 first index past the bank

        // R8: short low pulse inside the guard window
        sclk_div = 16'd0;
        do_read(4'd1, 24'h0F0F0F, 1'b1);
        r0 = rises;
        spi_miso = 1'b0;
        repeat (4) @(negedge clk);
        spi_miso = 1'b1;
        repeat (100) @(negedge clk);
        chk(rises == r0, "R8 guard ignores ready", longint'(rises - r0), 0);

        // R9: timeout flag
        sclk_div = 16'd1;
        repeat (50) @(negedge clk);
        chk(timeout_err == 1'b0, "R9 no early error", longint'(timeout_err), 0);
        repeat (300) @(negedge clk);
        chk(timeout_err == 1'b1, "R9 error after limit", longint'(timeout_err), 1);
        do_read(4'd2, 24'h13579B, 1'b1);
        chk(timeout_err == 1'b0, "R9 error cleared", longint'(timeout_err), 0);
        repeat (60) @(negedge clk);

        // random traffic
        for (int n = 0; n < 70; n++) begin
            sclk_div = CNTW'($urandom_range(0, 3));
            do_read(4'($urandom_range(0, 5)), DW'($urandom), 1'($urandom));
            repeat ($urandom_range(45, 80)) @(negedge clk);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule